// File: doc/BRIEF.md
# Mixed-Function GPIO Port Controller

This block is a small general-purpose I/O port that sits behind a simple register bus. It has three bidirectional pins and one input-only pin. For each bidirectional pin it produces an output-enable and an output-data signal for an external pad driver. It also takes that pin's level from the pad, along with an analog-select flag from an analog configuration register that lives elsewhere. The fourth pin has no direction or latch bit. A static configuration input decides whether that pin serves as a data input or as an active-low reset input. In reset duty, its level drives an internal reset-request output.

Software reaches three registers through the bus:

- a direction register, where a 1 marks an input and a 0 marks an output;
- an output latch;
- a port view that shows the synchronized pin levels.

Reads are combinational from the current address. Writes land on the rising clock edge. Writing the port address updates the output latch. Pins with analog mode selected read as zero in the port view. However, their direction bit still governs their output driver.

Top module: `gpio_mixport`

## Requirements
- R1: A synchronous active-high reset leaves the following state. The direction register holds 0xFF, so every pin is an input and `pin_oe` is 0. The output latch holds 0, and `ext_rst_req` is 0.
- R2: For each bidirectional pin i, direction bit i = 0 drives `pin_oe[i]`=1 and `pin_out[i]`= latch bit i. Direction bit i = 1 gives `pin_oe[i]`=0. The direction register sits at address 2.
- R3: In the port view (address 0), bit i of a pin with `ana_sel[i]`=1 reads 0 whatever the pin level.
- R4: Analog selection does not change `pin_oe`. A 0 in the direction register still enables the driver of an analog-selected pin.
- R5: The latch view (address 1) returns the stored latch bits [2:0], not the pin levels. Bits [7:3] read 0 and are not stored.
- R6: A write to the port address (0) updates the output latch exactly as a write to address 1 does.
- R7: Bit 3 of the port view follows the synchronized input-only pin when `cfg_rst_en`=0. When `cfg_rst_en`=1, that bit reads 0 and `ext_rst_req` is the inverse of the synchronized pin. When `cfg_rst_en`=0, `ext_rst_req` stays 0.
- R8: Direction bits [7:3] are plain storage. They read back as written and do not affect `pin_oe`.
- R9: A pin change becomes visible in the port view after exactly two rising clock edges, and not after one.
- R10: State changes only on a clock edge with `bus_we`=1. Reads follow the address with no clock edge. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rst_en | input | 1 | Static config: 1 = fourth pin is a reset input |
| bus_addr | input | 2 | Register address (0 port, 1 latch, 2 direction, 3 unused) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 4 | Pad levels; bit 3 is the input-only pin |
| ana_sel | input | 3 | Per-pin analog-select flags |
| pin_oe | output | 3 | Per-pin output enable (1 = drive) |
| pin_out | output | 3 | Per-pin output data |
| ext_rst_req | output | 1 | Reset request from the input-only pin |

## Verification
The assertions assume that the bus inputs are stable at every rising edge and that `cfg_rst_en` is treated as static. They place no constraint on `pin_in`, which may change at any time, because the synchronizer absorbs it. The stimulus drives every input on the falling edge. It changes `cfg_rst_en` only while the bus is idle, and it samples outputs one time unit after a falling edge. With this schedule, the two-edge synchronizer latency and the combinational reads can be checked at exact cycles.

// File: rtl/gpio_mixport_pkg.sv
package gpio_mixport_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic wr_latch;
        logic wr_dir;
    } wr_strobe_t;

    localparam logic [DATA_W-1:0] DIR_RESET = '1;

    // Port and latch addresses both land in the output latch.
    function automatic wr_strobe_t decode_write(input bus_req_t r);
        wr_strobe_t s;
        s = '0;
        if (r.we) begin
            s.wr_latch = (r.sel == REG_PORT) || (r.sel == REG_LATCH);
            s.wr_dir   = (r.sel == REG_DIR);
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_mixport_sync.sv
module gpio_mixport_sync #(
    parameter int   WIDTH   = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d[i];
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d[i]};
            end
        end
        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/gpio_mixport_regs.sv
module gpio_mixport_regs
    import gpio_mixport_pkg::*;
#(
    parameter int NUM_BIDIR = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    output logic [DATA_W-1:0]    dir_q,
    output logic [NUM_BIDIR-1:0] lat_q
);

    wr_strobe_t strobe;

    always_comb strobe = decode_write(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_RESET;
        end else if (strobe.wr_dir) begin
            dir_q <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (strobe.wr_latch) begin
            lat_q <= req.wdata[NUM_BIDIR-1:0];
        end
    end

endmodule

// File: rtl/gpio_mixport_rdmux.sv
module gpio_mixport_rdmux
    import gpio_mixport_pkg::*;
#(
    parameter int NUM_BIDIR = 3
) (
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    dir_q,
    input  logic [NUM_BIDIR-1:0] lat_q,
    input  logic [NUM_BIDIR:0]   pins_sync,
    input  logic [NUM_BIDIR-1:0] ana_sel,
    input  logic                 cfg_rst_en,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] port_v;
    logic [DATA_W-1:0] lat_v;

    always_comb begin
        port_v = '0;
        // Analog pins read as zero; the pad level is hidden.
        port_v[NUM_BIDIR-1:0] = pins_sync[NUM_BIDIR-1:0] & ~ana_sel;
        // Input-only pin is hidden while it serves as the reset input.
        port_v[NUM_BIDIR] = cfg_rst_en ? 1'b0 : pins_sync[NUM_BIDIR];

        lat_v = '0;
        lat_v[NUM_BIDIR-1:0] = lat_q;

        case (sel)
            REG_PORT:  rdata = port_v;
            REG_LATCH: rdata = lat_v;
            REG_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mixport_pad.sv
module gpio_mixport_pad #(
    parameter int NUM_BIDIR = 3
) (
    input  logic [NUM_BIDIR-1:0] dir_bits,
    input  logic [NUM_BIDIR-1:0] lat_q,
    output logic [NUM_BIDIR-1:0] oe,
    output logic [NUM_BIDIR-1:0] dout
);

    typedef struct packed {
        logic en;
        logic val;
    } pin_drive_t;

    for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_pin
        pin_drive_t drv;
        // Direction alone decides the driver; analog mode does not override it.
        assign drv.en  = ~dir_bits[i];
        assign drv.val = lat_q[i];
        assign oe[i]   = drv.en;
        assign dout[i] = drv.val;
    end

endmodule

// File: rtl/gpio_mixport.sv
module gpio_mixport
    import gpio_mixport_pkg::*;
#(
    parameter int NUM_BIDIR   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_PINS   = NUM_BIDIR + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_rst_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic [NUM_BIDIR-1:0] ana_sel,
    output logic [NUM_BIDIR-1:0] pin_oe,
    output logic [NUM_BIDIR-1:0] pin_out,
    output logic                 ext_rst_req
);

    bus_req_t             req;
    logic [DATA_W-1:0]    dir_q;
    logic [NUM_BIDIR-1:0] lat_q;
    logic [NUM_PINS-1:0]  pins_sync;

    always_comb begin
        req.we    = bus_we;
        req.sel   = reg_sel_e'(bus_addr);
        req.wdata = bus_wdata;
    end

    gpio_mixport_sync #(
        .WIDTH   (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpio_mixport_regs #(
        .NUM_BIDIR (NUM_BIDIR)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_mixport_rdmux #(
        .NUM_BIDIR (NUM_BIDIR)
    ) u_rdmux (
        .sel        (req.sel),
        .dir_q      (dir_q),
        .lat_q      (lat_q),
        .pins_sync  (pins_sync),
        .ana_sel    (ana_sel),
        .cfg_rst_en (cfg_rst_en),
        .rdata      (bus_rdata)
    );

    gpio_mixport_pad #(
        .NUM_BIDIR (NUM_BIDIR)
    ) u_pad (
        .dir_bits (dir_q[NUM_BIDIR-1:0]),
        .lat_q    (lat_q),
        .oe       (pin_oe),
        .dout     (pin_out)
    );

    // Active-low pin level requests a reset only in reset duty.
    assign ext_rst_req = cfg_rst_en & ~pins_sync[NUM_BIDIR];

endmodule

// File: rtl/gpio_mixport_chk.sv
module gpio_mixport_chk #(
    parameter int NUM_BIDIR = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_rst_en,
    input logic [1:0]           bus_addr,
    input logic                 bus_we,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [NUM_BIDIR-1:0] ana_sel,
    input logic [NUM_BIDIR-1:0] pin_oe,
    input logic [NUM_BIDIR-1:0] pin_out,
    input logic                 ext_rst_req
);

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=> (pin_oe == ~$past(bus_wdata[NUM_BIDIR-1:0])));

    p_analog_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> ((bus_rdata[NUM_BIDIR-1:0] & ana_sel) == '0));

    p_latch_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1) |-> (bus_rdata[7:NUM_BIDIR] == '0));

    p_port_write_latch_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1))
        |=> (pin_out == $past(bus_wdata[NUM_BIDIR-1:0])));

    p_rstpin_hidden_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rst_en && bus_addr == 2'd0) |-> !bus_rdata[NUM_BIDIR]);

    p_no_req_in_data_duty_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_en |-> !ext_rst_req);

    p_dir_readback_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2)
        |=> (bus_addr != 2'd2 || bus_rdata == $past(bus_wdata)));

    p_hold_without_we_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

    p_spare_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_spare_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

bind gpio_mixport gpio_mixport_chk #(.NUM_BIDIR(NUM_BIDIR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_rst_en  (cfg_rst_en),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ana_sel     (ana_sel),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .ext_rst_req (ext_rst_req)
);

// File: tb/gpio_mixport_bench.sv
module gpio_mixport_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rst_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = 4'hF;
    logic [2:0] ana_sel = 3'b111;
    logic [2:0] pin_oe;
    logic [2:0] pin_out;
    logic       ext_rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    gpio_mixport u_gpio_mixport (
        .clk         (clk),
        .rst         (rst),
        .cfg_rst_en  (cfg_rst_en),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .ana_sel     (ana_sel),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out),
        .ext_rst_req (ext_rst_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected at most 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'd2, v);
        check("R1 direction reset", v, 8'hFF);
        bus_read(2'd1, v);
        check("R1 latch reset", v, 8'h00);
        check("R1 pin_oe reset", {5'b0, pin_oe}, 8'h00);
        check("R1 pin_out reset", {5'b0, pin_out}, 8'h00);
        check("R1 ext_rst_req reset", {7'b0, ext_rst_req}, 8'h00);
    endtask

    task automatic t_direction();
        bus_write(2'd1, 8'h05);
        bus_write(2'd2, 8'hFA);
        #1;
        check("R2 pin_oe from dir 010", {5'b0, pin_oe}, 8'h05);
        check("R2 pin_out from latch", {5'b0, pin_out}, 8'h05);
        bus_write(2'd2, 8'hFF);
        #1;
        check("R2 all inputs", {5'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_analog();
        logic [7:0] v;
        @(negedge clk);
        ana_sel = 3'b111;
        pin_in  = 4'hF;
        settle();
        bus_read(2'd0, v);
        check("R3 all analog read zero", v & 8'h07, 8'h00);
        @(negedge clk);
        ana_sel = 3'b010;
        bus_read(2'd0, v);
        check("R3 pin1 analog masked", v, 8'h0D);
        @(negedge clk);
        ana_sel = 3'b111;
        bus_write(2'd2, 8'hF8);
        #1;
        check("R4 analog pins still driven", {5'b0, pin_oe}, 8'h07);
        bus_write(2'd2, 8'hFF);
    endtask

    task automatic t_latch_readback();
        logic [7:0] v;
        @(negedge clk);
        ana_sel = 3'b000;
        pin_in  = 4'h0;
        settle();
        bus_write(2'd1, 8'h07);
        bus_read(2'd1, v);
        check("R5 latch reads stored value", v, 8'h07);
        bus_read(2'd0, v);
        check("R5 port reads pins not latch", v, 8'h00);
        bus_write(2'd1, 8'hF8);
        bus_read(2'd1, v);
        check("R5 upper latch bits not stored", v, 8'h00);
    endtask

    task automatic t_port_write();
        logic [7:0] v;
        bus_write(2'd0, 8'h02);
        bus_read(2'd1, v);
        check("R6 port write sets latch", v, 8'h02);
        check("R6 pin_out after port write", {5'b0, pin_out}, 8'h02);
    endtask

    task automatic t_input_only();
        logic [7:0] v;
        @(negedge clk);
        cfg_rst_en = 1'b0;
        pin_in[3]  = 1'b1;
        settle();
        bus_read(2'd0, v);
        check("R7 data duty pin high", v & 8'h08, 8'h08);
        @(negedge clk);
        pin_in[3] = 1'b0;
        settle();
        bus_read(2'd0, v);
        check("R7 data duty pin low", v & 8'h08, 8'h00);
        check("R7 no request in data duty", {7'b0, ext_rst_req}, 8'h00);
        @(negedge clk);
        cfg_rst_en = 1'b1;
        pin_in[3]  = 1'b1;
        settle();
        bus_read(2'd0, v);
        check("R7 reset duty hides pin", v & 8'h08, 8'h00);
        check("R7 pin high no request", {7'b0, ext_rst_req}, 8'h00);
        @(negedge clk);
        pin_in[3] = 1'b0;
        settle();
        #1;
        check("R7 pin low requests reset", {7'b0, ext_rst_req}, 8'h01);
        @(negedge clk);
        pin_in[3]  = 1'b1;
        cfg_rst_en = 1'b0;
        settle();
    endtask

    task automatic t_upper_dir();
        logic [7:0] v;
        bus_write(2'd2, 8'hA8);
        bus_read(2'd2, v);
        check("R8 dir readback A8", v, 8'hA8);
        check("R8 upper bits no effect oe", {5'b0, pin_oe}, 8'h07);
        bus_write(2'd2, 8'h57);
        bus_read(2'd2, v);
        check("R8 dir readback 57", v, 8'h57);
        check("R8 upper bits no effect inputs", {5'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_sync_latency();
        @(negedge clk);
        ana_sel   = 3'b000;
        pin_in    = 4'h8;
        settle();
        @(negedge clk);
        bus_addr  = 2'd0;
        pin_in[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R9 not visible after one edge", bus_rdata & 8'h01, 8'h00);
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R9 visible after two edges", bus_rdata & 8'h01, 8'h01);
    endtask

    task automatic t_no_we();
        logic [7:0] v;
        bus_write(2'd1, 8'h03);
        bus_write(2'd2, 8'hF0);
        @(negedge clk);
        bus_addr  = 2'd1;
        bus_wdata = 8'h04;
        bus_we    = 1'b0;
        repeat (4) @(posedge clk);
        bus_read(2'd1, v);
        check("R10 no write without we", v, 8'h03);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v);
        check("R10 spare reads zero", v, 8'h00);
        bus_read(2'd1, v);
        check("R10 spare write leaves latch", v, 8'h03);
        bus_read(2'd2, v);
        check("R10 spare write leaves dir", v, 8'hF0);
        check("R10 pin_out unchanged", {5'b0, pin_out}, 8'h03);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direction();
        t_analog();
        t_latch_readback();
        t_port_write();
        t_input_only();
        t_upper_dir();
        t_sync_latency();
        t_no_we();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule